// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is one programmable cell of a lookup-table fabric. A configuration word sets a 16-entry truth table, an operating mode and a few flip-flop options. The cell has four data inputs, a carry input from the next lower-order cell, a cascade input from a neighbouring cell and four control lines. It drives a combinational result, a registered result, a carry output and a cascade output.

In normal mode the table computes any function of the four data inputs. The result can be ANDed with the cascade input, so that a chain of cells builds a wide AND. In arithmetic mode and in counter mode the table is split into two 8-entry halves. The lower half gives the result bit and the upper half gives the carry.

A counter bit uses one control line in one of two ways. It is either a count enable or a count direction, never both. A synchronous load from data input 1 overrides counting. The flip-flop has an asynchronous clear taken from one of two selectable control lines. An inversion option turns that clear into a preset. The configuration word is written through a parallel port, and the flip-flop holds its state during the write.

Top module: `lut_cell`

## Requirements
- R1: In mode 00 (normal) and mode 11 (spare), with cascade disabled, comb_out equals table bit {data[3],data[2],data[1],data[0]}, with data[0] as the least significant index bit.
- R2: In normal mode with config bit 22 set, comb_out is the table bit ANDed with casc_in. casc_out always carries the same value as comb_out.
- R3: In mode 01 (arithmetic), let idx = {carry_in,data[1],data[0]}. Then comb_out is table bit idx and carry_out is table bit 8+idx, and data[3:2] have no effect. In normal mode carry_out is 0.
- R4: In mode 10 (counter), let idx = {carry_in & enable, direction, reg_out}. On each rising edge reg_out takes table bit idx, and carry_out is table bit 8+idx. With config bit 21 clear, ctrl[2] is the enable and the direction is 1. With bit 21 set, ctrl[2] is the direction and the enable is 1.
- R5: In normal and arithmetic modes, reg_out takes the value of comb_out at each rising clock edge.
- R6: When ctrl[3] is high at a rising edge, reg_out takes data[0] instead of the table result, in every mode, including while counting.
- R7: With config bit 19 set, the clear line is chosen by bit 18: ctrl[0] when bit 18 is 0, ctrl[1] when it is 1. The chosen line clears the flip-flop at once and keeps it cleared while high. The other line has no effect.
- R8: With config bit 20 set, the clear drives reg_out to 1 instead of 0. Normal captures still store the true data value.
- R9: A config word presented with cfg_we high is loaded at the rising edge. At that edge the flip-flop keeps its stored state. The word holds the table in bits 15:0 and the mode in bits 17:16.
- R10: A synchronous rst clears the whole configuration and drives reg_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 23 | Configuration word |
| data | input | 4 | Data inputs 1..4 (bit 0 = input 1) |
| carry_in | input | 1 | Carry from the lower-order cell |
| casc_in | input | 1 | Cascade value from the neighbouring cell |
| ctrl | input | 4 | Clear candidates [1:0], count control [2], synchronous load [3] |
| comb_out | output | 1 | Combinational result |
| reg_out | output | 1 | Registered result |
| carry_out | output | 1 | Carry to the higher-order cell |
| casc_out | output | 1 | Cascade value to the next cell |

## Verification
comb_out, casc_out and carry_out react to data, carry and cascade inputs in the same cycle. reg_out and the loaded configuration change only at the next rising edge. The asynchronous clear acts at once, without waiting for an edge. The driver changes inputs at the falling edge and queues the expected values. The monitor compares them 1 ns after the following rising edge, so combinational results and captured results are checked at the same sampling point. In counter mode the carry is predicted from the register value after that edge. The effect of a clear is also sampled 1 ns after the falling-edge drive, before any clock edge could explain it.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ARITH  = 2'b01,
    MODE_COUNT  = 2'b10,
    MODE_SPARE  = 2'b11
  } cell_mode_e;

  // single-bit option fields placed after the table and the mode field
  localparam int OPT_BITS = 5;
endpackage

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg #(
  parameter int CFG_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (we) word <= wdata;
  end
endmodule

// File: rtl/lut_cell_logic.sv
module lut_cell_logic
  import lut_cell_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic [(1<<LUT_IN)-1:0] table_bits,
  input  cell_mode_e             mode,
  input  logic                   casc_en,
  input  logic                   dir_form,
  input  logic [LUT_IN-1:0]      data,
  input  logic                   cin,
  input  logic                   casc_in,
  input  logic                   state,
  input  logic                   cnt_line,
  output logic                   result,
  output logic                   cout
);
  localparam int HIDX_W = LUT_IN - 1;

  logic [HIDX_W-1:0] ar_idx;
  logic [HIDX_W-1:0] ct_idx;
  logic              cnt_en;
  logic              cnt_dir;
  logic              full_bit;

  always_comb begin
    cnt_en   = dir_form ? 1'b1 : cnt_line;
    cnt_dir  = dir_form ? cnt_line : 1'b1;
    ar_idx   = {cin, data[LUT_IN-3:0]};
    ct_idx   = '0;
    ct_idx[2:0] = {cin & cnt_en, cnt_dir, state};
    full_bit = table_bits[data];
    unique case (mode)
      MODE_ARITH: begin
        result = table_bits[{1'b0, ar_idx}];
        cout   = table_bits[{1'b1, ar_idx}];
      end
      MODE_COUNT: begin
        result = table_bits[{1'b0, ct_idx}];
        cout   = table_bits[{1'b1, ct_idx}];
      end
      default: begin
        result = full_bit & (casc_en ? casc_in : 1'b1);
        cout   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
  input  logic clk,
  input  logic rst,
  input  logic aclr,
  input  logic hold,
  input  logic load,
  input  logic load_val,
  input  logic d,
  input  logic inv,
  output logic q
);
  logic st;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      st <= 1'b0;
    else if (rst)  st <= 1'b0;
    else if (!hold) st <= (load ? load_val : d) ^ inv;
  end

  assign q = st ^ inv;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int LUT_IN = 4,
  parameter int CTRL_W = 4,
  localparam int LUT_W = 1 << LUT_IN,
  localparam int CFG_W = LUT_W + 2 + OPT_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [LUT_IN-1:0] data,
  input  logic              carry_in,
  input  logic              casc_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              comb_out,
  output logic              reg_out,
  output logic              carry_out,
  output logic              casc_out
);
  localparam int MODE_LO = LUT_W;
  localparam int SEL_B   = LUT_W + 2;
  localparam int CLREN_B = LUT_W + 3;
  localparam int INV_B   = LUT_W + 4;
  localparam int DIR_B   = LUT_W + 5;
  localparam int CASC_B  = LUT_W + 6;
  localparam int LD_LINE = CTRL_W - 1;
  localparam int CN_LINE = CTRL_W - 2;

  logic [CFG_W-1:0] word;
  cell_mode_e       mode_w;
  logic             clr_sel_w, clr_en_w, inv_w, dir_form_w, casc_en_w;
  logic             aclr_w;

  lut_cell_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_data), .word(word)
  );

  assign mode_w     = cell_mode_e'(word[MODE_LO+1:MODE_LO]);
  assign clr_sel_w  = word[SEL_B];
  assign clr_en_w   = word[CLREN_B];
  assign inv_w      = word[INV_B];
  assign dir_form_w = word[DIR_B];
  assign casc_en_w  = word[CASC_B];
  assign aclr_w     = clr_en_w & (clr_sel_w ? ctrl[1] : ctrl[0]);

  lut_cell_logic #(.LUT_IN(LUT_IN)) u_logic (
    .table_bits(word[LUT_W-1:0]),
    .mode(mode_w),
    .casc_en(casc_en_w),
    .dir_form(dir_form_w),
    .data(data),
    .cin(carry_in),
    .casc_in(casc_in),
    .state(reg_out),
    .cnt_line(ctrl[CN_LINE]),
    .result(comb_out),
    .cout(carry_out)
  );

  lut_cell_ff u_ff (
    .clk(clk), .rst(rst), .aclr(aclr_w), .hold(cfg_we),
    .load(ctrl[LD_LINE]), .load_val(data[0]), .d(comb_out),
    .inv(inv_w), .q(reg_out)
  );

  assign casc_out = comb_out;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic       ld,
  input logic       d1,
  input logic       casc_in,
  input logic       comb_out,
  input logic       reg_out,
  input logic       carry_out,
  input logic [1:0] mode,
  input logic       casc_en,
  input logic       inv,
  input logic       aclr
);
  AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |-> !carry_out); // R3

  AST_CASCADE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (casc_en && !casc_in && (mode == 2'b00 || mode == 2'b11)) |-> !comb_out); // R2

  AST_LOAD_TAKES_D1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && ld && !aclr) |=> (aclr || reg_out == $past(d1))); // R6

  AST_CLEAR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    aclr |-> (reg_out == inv)); // R7

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst) && !$past(aclr) && !aclr && $stable(inv))
      |-> $stable(reg_out)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !reg_out); // R10
endmodule

bind lut_cell lut_cell_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .ld(ctrl[CTRL_W-1]), .d1(data[0]),
  .casc_in(casc_in), .comb_out(comb_out), .reg_out(reg_out),
  .carry_out(carry_out), .mode(word[LUT_W+1:LUT_W]), .casc_en(casc_en_w),
  .inv(inv_w), .aclr(aclr_w)
);

// File: tb/lut_cell_test.sv
`timescale 1ns/1ps
module lut_cell_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [22:0] cfg_data = '0;
  logic [3:0]  data = '0;
  logic        carry_in = 1'b0;
  logic        casc_in = 1'b0;
  logic [3:0]  ctrl = '0;
  logic        comb_out, reg_out, carry_out, casc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { string req; int sig; logic exp; } item_t;
  item_t sb[$];

  lut_cell uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data), .data(data),
    .carry_in(carry_in), .casc_in(casc_in), .ctrl(ctrl),
    .comb_out(comb_out), .reg_out(reg_out), .carry_out(carry_out),
    .casc_out(casc_out)
  );

  always #2 clk = ~clk;

  function automatic logic [22:0] mk(logic [15:0] tbl, logic [1:0] md, bit sel,
                                     bit clren, bit inv, bit dirf, bit casc);
    return {casc, dirf, inv, clren, sel, md, tbl};
  endfunction

  function automatic logic pick(int sig);
    case (sig)
      0: return comb_out;
      1: return reg_out;
      2: return carry_out;
      default: return casc_out;
    endcase
  endfunction

  function automatic string sname(int sig);
    case (sig)
      0: return "comb_out";
      1: return "reg_out";
      2: return "carry_out";
      default: return "casc_out";
    endcase
  endfunction

  task automatic compare(string req, int sig, logic exp);
    logic act;
    act = pick(sig);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, sname(sig), act, exp, $time);
    end
  endtask

  task automatic expect_at(string req, int sig, logic exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic check_now(string req, int sig, logic exp);
    #1;
    compare(req, sig, exp);
  endtask

  task automatic step(logic [3:0] d, logic ci, logic cs, logic [3:0] c,
                      logic we, logic [22:0] w, logic r);
    @(negedge clk);
    data = d; carry_in = ci; casc_in = cs; ctrl = c;
    cfg_we = we; cfg_data = w; rst = r;
  endtask

  task automatic run(logic [3:0] d, logic ci, logic cs, logic [3:0] c);
    step(d, ci, cs, c, 1'b0, '0, 1'b0);
  endtask

  task automatic load(logic [22:0] w, logic [3:0] d);
    step(d, 1'b0, 1'b0, 4'b0000, 1'b1, w, 1'b0);
  endtask

  // monitor: results are due 1 ns after the rising edge that follows the drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        compare(it.req, it.sig, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, b, ci, p;
    // R10 reset state
    step(4'h0, 0, 0, 4'h0, 0, '0, 1);
    step(4'h0, 0, 0, 4'h0, 0, '0, 1);
    expect_at("R10", 1, 1'b0);
    expect_at("R10", 0, 1'b0);

    // R9 parity table loaded, register held
    load(mk(16'h6996, 2'b00, 0, 0, 0, 0, 0), 4'b0001);
    expect_at("R9", 0, 1'b1);
    expect_at("R9", 1, 1'b0);

    // R1 R5 R2 R3 all sixteen input patterns
    for (int d = 0; d < 16; d++) begin
      run(4'(d), 0, 0, 4'h0);
      p = ^4'(d);
      expect_at("R1", 0, p);
      expect_at("R5", 1, p);
      expect_at("R2", 3, p);
      expect_at("R3", 2, 1'b0);
    end

    // R1 spare mode behaves as normal (4-input AND)
    load(mk(16'h8000, 2'b11, 0, 0, 0, 0, 0), 4'hF);
    expect_at("R1", 0, 1'b1);
    expect_at("R9", 1, 1'b0);
    run(4'hE, 0, 0, 4'h0); expect_at("R1", 0, 1'b0); expect_at("R5", 1, 1'b0);
    run(4'hF, 0, 0, 4'h0); expect_at("R1", 0, 1'b1); expect_at("R5", 1, 1'b1);

    // R2 cascade AND with OR table
    load(mk(16'hFFFE, 2'b00, 0, 0, 0, 0, 1), 4'h0);
    expect_at("R2", 0, 1'b0);
    expect_at("R9", 1, 1'b1);
    run(4'h1, 0, 0, 4'h0); expect_at("R2", 0, 1'b0); expect_at("R2", 3, 1'b0);
    run(4'h1, 0, 1, 4'h0); expect_at("R2", 0, 1'b1); expect_at("R2", 3, 1'b1);
    expect_at("R5", 1, 1'b1);
    run(4'h0, 0, 1, 4'h0); expect_at("R2", 0, 1'b0);

    // R3 full adder in arithmetic mode, data[3:2] held high
    load(mk(16'hE896, 2'b01, 0, 0, 0, 0, 0), 4'h0);
    expect_at("R3", 0, 1'b0);
    expect_at("R9", 1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      a = k[0]; b = k[1]; ci = k[2];
      run({2'b11, b, a}, ci, 0, 4'h0);
      expect_at("R3", 0, a ^ b ^ ci);
      expect_at("R3", 2, (a & b) | (a & ci) | (b & ci));
      expect_at("R5", 1, a ^ b ^ ci);
    end

    // R4 R6 counter, enable form
    load(mk(16'h905A, 2'b10, 0, 0, 0, 0, 0), 4'h0);
    expect_at("R9", 1, 1'b1);
    run(4'h0, 0, 0, 4'b1000); expect_at("R6", 1, 1'b0);
    run(4'h1, 0, 0, 4'b1000); expect_at("R6", 1, 1'b1);
    run(4'h0, 1, 0, 4'b0100); expect_at("R4", 1, 1'b0); expect_at("R4", 2, 1'b0);
    run(4'h0, 1, 0, 4'b0100); expect_at("R4", 1, 1'b1); expect_at("R4", 2, 1'b1);
    run(4'h0, 1, 0, 4'b0000); expect_at("R4", 1, 1'b1); expect_at("R4", 2, 1'b0);
    run(4'h0, 0, 0, 4'b0100); expect_at("R4", 1, 1'b1);
    run(4'h0, 1, 0, 4'b1100); expect_at("R6", 1, 1'b0);

    // R4 counter, up/down form
    load(mk(16'h905A, 2'b10, 0, 0, 0, 1, 0), 4'h0);
    expect_at("R9", 1, 1'b0);
    run(4'h0, 1, 0, 4'b0000); expect_at("R4", 1, 1'b1); expect_at("R4", 2, 1'b0);
    run(4'h0, 1, 0, 4'b0000); expect_at("R4", 1, 1'b0); expect_at("R4", 2, 1'b1);
    run(4'h0, 1, 0, 4'b0100); expect_at("R4", 1, 1'b1); expect_at("R4", 2, 1'b1);
    run(4'h0, 1, 0, 4'b0100); expect_at("R4", 1, 1'b0); expect_at("R4", 2, 1'b0);

    // R7 clear line selection
    load(mk(16'hFFFF, 2'b00, 0, 1, 0, 0, 0), 4'h0);
    expect_at("R7", 0, 1'b1);
    expect_at("R9", 1, 1'b0);
    run(4'h0, 0, 0, 4'b0000); expect_at("R5", 1, 1'b1);
    run(4'h0, 0, 0, 4'b0010); expect_at("R7", 1, 1'b1);
    run(4'h0, 0, 0, 4'b0001); check_now("R7", 1, 1'b0); expect_at("R7", 1, 1'b0);
    run(4'h0, 0, 0, 4'b0000); expect_at("R7", 1, 1'b1);
    load(mk(16'hFFFF, 2'b00, 1, 1, 0, 0, 0), 4'h0);
    expect_at("R9", 1, 1'b1);
    run(4'h0, 0, 0, 4'b0001); expect_at("R7", 1, 1'b1);
    run(4'h0, 0, 0, 4'b0010); check_now("R7", 1, 1'b0); expect_at("R7", 1, 1'b0);
    run(4'h0, 0, 0, 4'b0000); expect_at("R7", 1, 1'b1);

    // R8 clear acts as preset under inversion
    load(mk(16'h0000, 2'b00, 0, 1, 1, 0, 0), 4'h0);
    expect_at("R8", 0, 1'b0);
    run(4'h0, 0, 0, 4'b0000); expect_at("R8", 1, 1'b0);
    run(4'h0, 0, 0, 4'b0001); check_now("R8", 1, 1'b1); expect_at("R8", 1, 1'b1);
    run(4'h0, 0, 0, 4'b0000); expect_at("R8", 1, 1'b0);
    run(4'h0, 0, 0, 4'b0001); expect_at("R8", 1, 1'b1);

    // R10 reset from a configured, set state
    step(4'hF, 0, 0, 4'b0001, 0, '0, 1);
    expect_at("R10", 1, 1'b0);
    expect_at("R10", 0, 1'b0);
    run(4'hF, 0, 0, 4'h0);
    expect_at("R10", 0, 1'b0);
    expect_at("R10", 1, 1'b0);

    @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule